// File: doc/BRIEF.md
# Legacy System Control Port Block

This block sits on a narrow I/O bus (16-bit port address, 8-bit data) and holds three small pieces of legacy PC system control. Port 0x92 carries the fast address-line-20 gate: software writes the gate enable in data bit 1 and reads it back in the same position. The gate drives the memory address path directly through `a20_gate`.

A floating-point error pulse from the numeric unit sets a sticky request, `ferr_irq`, meant to be wired to interrupt line 13 of the interrupt controller. The handler clears it by writing anything to port 0xF0. Port 0x80, the power-on self-test progress port, takes writes and throws them away.

Accesses are single-cycle strobes. A write takes effect on the clock edge where `wr_en` is sampled. Read data is registered and appears on `rdata` one cycle after `rd_en`. When no read was strobed in the previous cycle, `rdata` is zero.

Top module: `sys_ctl_ports`

## Requirements
- R1: While `rst_n` is low and right after it, `a20_gate` is 0, `ferr_irq` is 0 and `rdata` is 0x00.
- R2: A write to port 0x92 sets `a20_gate` to data bit 1 on the next clock edge, and it holds until the next such write.
- R3: Bit 0 of a port 0x92 write (fast reset) and bits 7..2 are not stored. A later read of 0x92 shows 0 in every bit except bit 1.
- R4: A read of port 0x92 returns 0x02 when the gate is on and 0x00 when it is off, on `rdata` one cycle after `rd_en`. The value is the gate as it stood in the read cycle.
- R5: A one-cycle high on `fpu_err` sets `ferr_irq` from the next edge, and it stays high without further pulses.
- R6: Any write to port 0xF0, whatever the data, clears `ferr_irq` on the next edge.
- R7: When `fpu_err` is high in the same cycle as a port 0xF0 write, `ferr_irq` is 1 afterwards (the set wins).
- R8: Writes to port 0x80, or to any port other than 0x92 and 0xF0, leave `a20_gate` and `ferr_irq` unchanged.
- R9: Reads of ports 0x80 and 0xF0 return 0xFF and change no state. Reads of any other port return 0x00. `rdata` is 0x00 in the cycle after a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 16 | I/O port address |
| wdata | input | 8 | Write data |
| fpu_err | input | 1 | Floating-point error pulse |
| rdata | output | 8 | Registered read data |
| a20_gate | output | 1 | Address line 20 gate enable |
| ferr_irq | output | 1 | Sticky floating-point error interrupt request |

## Verification
The two functions that can collide are the asynchronous-to-software error pulse setting the request, and the clear write to port 0xF0. The bench drives `fpu_err` high in the very cycle it strobes a 0xF0 write. It then requires `ferr_irq` to read 1 afterwards. A plain clear write follows, and it must bring the request back to 0. This shows that the set won the collision and that the clear path still works.

// File: rtl/sys_ctl_ports.sv
module sys_ctl_ports #(
  parameter int          AW        = 16,
  parameter int          DW        = 8,
  parameter logic [15:0] GATE_PORT = 16'h0092,
  parameter logic [15:0] ERRC_PORT = 16'h00F0,
  parameter logic [15:0] POST_PORT = 16'h0080,
  parameter int          GATE_BIT  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          fpu_err,
  output logic [DW-1:0] rdata,
  output logic          a20_gate,
  output logic          ferr_irq
);

  localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};

  logic hit_gate, hit_errc, hit_post;
  logic [DW-1:0] rd_mux;

  assign hit_gate = (addr == AW'(GATE_PORT));
  assign hit_errc = (addr == AW'(ERRC_PORT));
  assign hit_post = (addr == AW'(POST_PORT));

  always_comb begin
    rd_mux = '0;
    if (hit_gate)
      rd_mux[GATE_BIT] = a20_gate;
    else if (hit_errc || hit_post)
      rd_mux = ALL_ONES;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      a20_gate <= 1'b0;
    else if (wr_en && hit_gate)
      a20_gate <= wdata[GATE_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ferr_irq <= 1'b0;
    else if (fpu_err)
      ferr_irq <= 1'b1;
    else if (wr_en && hit_errc)
      ferr_irq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata <= '0;
    else
      rdata <= rd_en ? rd_mux : '0;
  end

endmodule

// File: rtl/sys_ctl_ports_chk.sv
module sys_ctl_ports_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [15:0] addr,
  input logic [7:0]  wdata,
  input logic        fpu_err,
  input logic [7:0]  rdata,
  input logic        a20_gate,
  input logic        ferr_irq
);

  p_gate_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 16'h0092) |=> (a20_gate == $past(wdata[1])));

  p_gate_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 16'h0092) |=> $stable(a20_gate));

  p_gate_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 16'h0092) |=> (rdata == {6'b0, $past(a20_gate), 1'b0}));

  p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fpu_err |=> ferr_irq);

  p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 16'h00F0 && !fpu_err) |=> !ferr_irq);

  p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fpu_err && !(wr_en && addr == 16'h00F0)) |=> $stable(ferr_irq));

  p_idle_rdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == 8'h00));

endmodule

bind sys_ctl_ports sys_ctl_ports_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .fpu_err(fpu_err), .rdata(rdata), .a20_gate(a20_gate),
  .ferr_irq(ferr_irq)
);

// File: tb/sim_sys_ctl_ports.sv
module sim_sys_ctl_ports;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, fpu_err = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic a20_gate, ferr_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sys_ctl_ports u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .fpu_err(fpu_err), .rdata(rdata), .a20_gate(a20_gate),
    .ferr_irq(ferr_irq)
  );

  // {op(0 idle,1 wr,2 rd), addr, data, fpu_err, exp_gate, exp_irq, exp_rdata}
  localparam int NV = 18;
  localparam logic [36:0] VEC [NV] = '{
    {2'd1, 16'h0092, 8'h02, 1'b0, 1'b1, 1'b0, 8'h00}, // R2
    {2'd2, 16'h0092, 8'h00, 1'b0, 1'b1, 1'b0, 8'h02}, // R4
    {2'd1, 16'h0092, 8'h01, 1'b0, 1'b0, 1'b0, 8'h00}, // R3 bit0 only
    {2'd2, 16'h0092, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}, // R4
    {2'd1, 16'h0092, 8'hFF, 1'b0, 1'b1, 1'b0, 8'h00}, // R2
    {2'd2, 16'h0092, 8'h00, 1'b0, 1'b1, 1'b0, 8'h02}, // R3 other bits zero
    {2'd1, 16'h0080, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // R8
    {2'd1, 16'h0080, 8'hFF, 1'b0, 1'b1, 1'b0, 8'h00}, // R8
    {2'd0, 16'h0000, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00}, // R5 set
    {2'd0, 16'h0000, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00}, // R5 hold
    {2'd2, 16'h00F0, 8'h00, 1'b0, 1'b1, 1'b1, 8'hFF}, // R9
    {2'd2, 16'h0080, 8'h00, 1'b0, 1'b1, 1'b1, 8'hFF}, // R9
    {2'd1, 16'h0080, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00}, // R8
    {2'd1, 16'h00F0, 8'hA5, 1'b0, 1'b1, 1'b0, 8'h00}, // R6
    {2'd1, 16'h00F0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h00}, // R7 collision
    {2'd1, 16'h00F0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // R6
    {2'd2, 16'h1234, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // R9 unmapped
    {2'd1, 16'h0093, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}  // R8 near miss
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 gate", {7'b0, a20_gate}, 8'h00);
    check("R1 irq", {7'b0, ferr_irq}, 8'h00);
    check("R1 rdata", rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 gate after release", {7'b0, a20_gate}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr_en   = (VEC[i][36:35] == 2'd1);
      rd_en   = (VEC[i][36:35] == 2'd2);
      addr    = VEC[i][34:19];
      wdata   = VEC[i][18:11];
      fpu_err = VEC[i][10];
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; fpu_err = 1'b0;
      check($sformatf("vec%0d gate", i), {7'b0, a20_gate}, {7'b0, VEC[i][9]});
      check($sformatf("vec%0d irq", i), {7'b0, ferr_irq}, {7'b0, VEC[i][8]});
      check($sformatf("vec%0d rdata", i), rdata, VEC[i][7:0]);
    end

    // R9: rdata returns to zero after an idle cycle
    rd_en = 1'b1; addr = 16'h0080;
    @(negedge clk);
    rd_en = 1'b0;
    check("R9 read 80", rdata, 8'hFF);
    @(negedge clk);
    check("R9 idle rdata", rdata, 8'h00);

    // R4: read in the same cycle as a write sees the old gate value
    wr_en = 1'b1; rd_en = 1'b1; addr = 16'h0092; wdata = 8'h00;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R4 old value on collision", rdata, 8'h02);
    check("R2 gate cleared", {7'b0, a20_gate}, 8'h00);

    // R1: reset mid-run with both state bits set
    wr_en = 1'b1; addr = 16'h0092; wdata = 8'h02; fpu_err = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; fpu_err = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 gate on reset", {7'b0, a20_gate}, 8'h00);
    check("R1 irq on reset", {7'b0, ferr_irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    finish_run();
  end
endmodule